// File: doc/BRIEF.md
# Single-Cycle RISC Processor Core

This block is a 32-bit processor core that fetches, decodes and completes one instruction in every clock cycle. It holds a program counter, a 32-by-32-bit register file, a word-addressed instruction store and a word-addressed data store. All three storage arrays read combinationally and update only on the rising clock edge. Each instruction is therefore one long combinational path, from the program counter through decode, register read, extension, ALU and data read to the write-back. The path closes at the next rising edge, where the register file, the data store and the program counter all update.

Decode has two levels. A main decoder turns the 6-bit opcode into a small set of datapath controls and a coarse ALU request. A local ALU decoder resolves that request, together with the function field of register-register instructions, into one of three ALU functions: add, subtract or OR. The core understands seven instructions: add, sub, ori, lw, sw, beq and j. Every other encoding runs as a no-op. The instruction and data stores are internal arrays, which the surrounding test environment preloads and inspects.

Top module: `onecyc_core`

## Requirements
- R1: With opcode 000000 and function field (bits 5:0) 100000, the register named by bits 15:11 receives the register named by bits 25:21 plus the register named by bits 20:16, modulo 2^32. With function field 100010 it receives the difference of the same two registers.
- R2: Opcode 001101 writes the register named by bits 20:16 with the register named by bits 25:21 ORed with the 16-bit immediate (bits 15:0) zero-extended. The register named by bits 15:11 is left unchanged.
- R3: Opcode 100011 forms an address as the register in bits 25:21 plus the sign-extended immediate. It then loads the data word at word index address[7:2] (64 words, address bits 1:0 ignored) into the register in bits 20:16.
- R4: Opcode 101011 stores the register in bits 20:16 into the data word chosen as in R3, and writes no register.
- R5: Opcode 000100 compares the registers in bits 25:21 and 20:16 by subtraction. When they are equal the next PC is PC+4 plus the sign-extended immediate shifted left by two. Otherwise the next PC is PC+4. No register or data word is written.
- R6: Opcode 000010 sets the next PC to {(PC+4)[31:28], bits 25:0, 2'b00} and writes nothing.
- R7: Any opcode other than the six above, and opcode 000000 with any other function field, is a no-op: the PC advances by 4 and nothing is written. Every instruction that is neither a taken branch nor a jump advances the PC by exactly 4.
- R8: Register 0 reads as zero whatever its storage holds, and a write aimed at register 0 leaves that storage unchanged.
- R9: The instruction executed is the instruction-store word at index PC[7:2], and its effects appear at the next rising edge. When rst_i is high at a rising edge, the PC becomes 0 and no register or data word is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state updates on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Current program counter |

## Verification
Every result of an instruction is due at the first rising edge after that instruction's word is addressed by the PC. After reset is released on a falling edge, N rising edges therefore complete exactly N instructions. The bench releases reset on a falling edge, counts the rising edges a program needs, and samples the PC, every register and every data word on the following falling edge. Branch and jump targets are sampled one edge at a time, so the PC taken after each control transfer is checked in the cycle it lands. Reset checks look at the PC one edge after reset is raised, and again after further edges held in reset.

// File: rtl/onecyc_pkg.sv
package onecyc_pkg;

   // Opcode values (instruction bits 31:26)
   localparam logic [5:0] OPC_REG   = 6'b000000;
   localparam logic [5:0] OPC_JMP   = 6'b000010;
   localparam logic [5:0] OPC_BEQ   = 6'b000100;
   localparam logic [5:0] OPC_ORI   = 6'b001101;
   localparam logic [5:0] OPC_LOAD  = 6'b100011;
   localparam logic [5:0] OPC_STORE = 6'b101011;

   // Function field values for register-register operations
   localparam logic [5:0] FUNCT_ADD = 6'b100000;
   localparam logic [5:0] FUNCT_SUB = 6'b100010;

   // Coarse ALU request from the main decoder
   typedef enum logic [1:0] {
      AREQ_FUNCT = 2'd0,
      AREQ_OR    = 2'd1,
      AREQ_ADD   = 2'd2,
      AREQ_SUB   = 2'd3
   } alu_req_e;

   // Resolved ALU function
   typedef enum logic [1:0] {
      ALU_ADD = 2'd0,
      ALU_SUB = 2'd1,
      ALU_OR  = 2'd2
   } alu_fn_e;

   // Datapath control points from the main decoder
   typedef struct packed {
      logic dst_rd;    // destination from bits 15:11 instead of 20:16
      logic src_imm;   // second operand is the extended immediate
      logic ext_sign;  // sign-extend instead of zero-extend
      logic wb_mem;    // write back the data word instead of the ALU result
      logic reg_we;    // write a register
      logic mem_we;    // write a data word
      logic branch;    // conditional branch on the zero flag
      logic jump;      // unconditional region jump
   } ctl_t;

endpackage

// File: rtl/onecyc_main_ctl.sv
module onecyc_main_ctl
   import onecyc_pkg::*;
(
   input  logic [5:0] op_i,
   output ctl_t       ctl_o,
   output alu_req_e   areq_o
);

   always_comb begin
      ctl_o  = '0;
      areq_o = AREQ_ADD;
      case (op_i)
         OPC_REG: begin
            ctl_o.dst_rd = 1'b1;
            ctl_o.reg_we = 1'b1;
            areq_o       = AREQ_FUNCT;
         end
         OPC_ORI: begin
            ctl_o.src_imm = 1'b1;
            ctl_o.reg_we  = 1'b1;
            areq_o        = AREQ_OR;
         end
         OPC_LOAD: begin
            ctl_o.src_imm  = 1'b1;
            ctl_o.ext_sign = 1'b1;
            ctl_o.wb_mem   = 1'b1;
            ctl_o.reg_we   = 1'b1;
            areq_o         = AREQ_ADD;
         end
         OPC_STORE: begin
            ctl_o.src_imm  = 1'b1;
            ctl_o.ext_sign = 1'b1;
            ctl_o.mem_we   = 1'b1;
            areq_o         = AREQ_ADD;
         end
         OPC_BEQ: begin
            ctl_o.ext_sign = 1'b1;
            ctl_o.branch   = 1'b1;
            areq_o         = AREQ_SUB;
         end
         OPC_JMP: begin
            ctl_o.jump = 1'b1;
         end
         default: begin
            ctl_o = '0;
         end
      endcase
   end

endmodule

// File: rtl/onecyc_alu_ctl.sv
module onecyc_alu_ctl
   import onecyc_pkg::*;
(
   input  alu_req_e   areq_i,
   input  logic [5:0] funct_i,
   output alu_fn_e    fn_o,
   output logic       fn_ok_o
);

   always_comb begin
      fn_o    = ALU_ADD;
      fn_ok_o = 1'b1;
      case (areq_i)
         AREQ_FUNCT: begin
            case (funct_i)
               FUNCT_ADD: fn_o = ALU_ADD;
               FUNCT_SUB: fn_o = ALU_SUB;
               default: begin
                  fn_o    = ALU_ADD;
                  fn_ok_o = 1'b0;
               end
            endcase
         end
         AREQ_OR:  fn_o = ALU_OR;
         AREQ_SUB: fn_o = ALU_SUB;
         default:  fn_o = ALU_ADD;
      endcase
   end

endmodule

// File: rtl/onecyc_alu.sv
module onecyc_alu
   import onecyc_pkg::*;
#(
   parameter int unsigned W            = 32,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  alu_fn_e      fn_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] res_o,
   output logic         zero_o
);

   logic [W-1:0] arith;

   if (SHARED_ADDER) begin : g_shared
      // one carry-in adder serves both add and subtract
      logic         inv_b;
      logic [W-1:0] b_eff;
      assign inv_b = (fn_i == ALU_SUB);
      assign b_eff = inv_b ? ~b_i : b_i;
      assign arith = a_i + b_eff + W'(inv_b);
   end else begin : g_split
      logic [W-1:0] sum_v;
      logic [W-1:0] dif_v;
      assign sum_v = a_i + b_i;
      assign dif_v = a_i - b_i;
      assign arith = (fn_i == ALU_SUB) ? dif_v : sum_v;
   end

   assign res_o  = (fn_i == ALU_OR) ? (a_i | b_i) : arith;
   assign zero_o = (res_o == '0);

endmodule

// File: rtl/onecyc_regfile.sv
module onecyc_regfile #(
   parameter int unsigned W        = 32,
   parameter int unsigned NREG     = 32,
   parameter bit          ZERO_REG = 1'b1,
   localparam int unsigned AW      = $clog2(NREG)
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic [AW-1:0] ra_i,
   input  logic [AW-1:0] rb_i,
   output logic [W-1:0]  rda_o,
   output logic [W-1:0]  rdb_o,
   input  logic          we_i,
   input  logic [AW-1:0] wa_i,
   input  logic [W-1:0]  wd_i
);

   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("onecyc_regfile: NREG must be a power of two of at least 2");
   end

   logic [W-1:0] regs_q [NREG];
   logic         wr_ok;

   if (ZERO_REG) begin : g_zero
      assign wr_ok = we_i && (wa_i != '0);
      assign rda_o = (ra_i == '0) ? '0 : regs_q[ra_i];
      assign rdb_o = (rb_i == '0) ? '0 : regs_q[rb_i];

      // R8: a write aimed at entry 0 leaves its storage alone
      a_r8_zero_entry_kept: assert property (@(posedge clk_i) disable iff (rst_i)
         (we_i && wa_i == '0) |=> regs_q[0] == $past(regs_q[0]));
   end else begin : g_plain
      assign wr_ok = we_i;
      assign rda_o = regs_q[ra_i];
      assign rdb_o = regs_q[rb_i];
   end

   always_ff @(posedge clk_i) begin
      if (wr_ok) begin
         regs_q[wa_i] <= wd_i;
      end
   end

endmodule

// File: rtl/onecyc_pc_unit.sv
module onecyc_pc_unit #(
   parameter int unsigned W = 32
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         branch_i,
   input  logic         zero_i,
   input  logic         jump_i,
   input  logic [15:0]  imm_i,
   input  logic [25:0]  target_i,
   output logic [W-1:0] pc_o
);

   localparam int unsigned HI_W = W - 28;

   logic [W-1:0] pc_q;
   logic [W-1:0] seq_pc;
   logic [W-1:0] br_off;
   logic [W-1:0] br_pc;
   logic [W-1:0] jmp_pc;
   logic [W-1:0] next_pc;

   assign seq_pc = pc_q + W'(4);
   assign br_off = {{(W - 18){imm_i[15]}}, imm_i, 2'b00};
   assign br_pc  = seq_pc + br_off;
   assign jmp_pc = {seq_pc[W-1 -: HI_W], target_i, 2'b00};

   always_comb begin
      if (jump_i) begin
         next_pc = jmp_pc;
      end else if (branch_i && zero_i) begin
         next_pc = br_pc;
      end else begin
         next_pc = seq_pc;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pc_q <= '0;
      end else begin
         pc_q <= next_pc;
      end
   end

   assign pc_o = pc_q;

   // R9: reset returns the PC to zero
   a_r9_pc_reset: assert property (@(posedge clk_i)
      rst_i |=> pc_q == '0);

   // R7: anything but a taken branch or a jump steps by one word
   a_r7_seq_step: assert property (@(posedge clk_i) disable iff (rst_i)
      (!jump_i && !(branch_i && zero_i)) |=> pc_q == $past(pc_q) + W'(4));

   // R6: a jump keeps the top four bits of the incremented PC
   a_r6_jump_region: assert property (@(posedge clk_i) disable iff (rst_i)
      jump_i |=> pc_q[W-1 -: 4] == $past(seq_pc[W-1 -: 4]));

endmodule

// File: rtl/onecyc_core.sv
module onecyc_core
   import onecyc_pkg::*;
#(
   parameter int unsigned XLEN         = 32,
   parameter int unsigned NREG         = 32,
   parameter int unsigned IMEM_WORDS   = 64,
   parameter int unsigned DMEM_WORDS   = 64,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_i,
   output logic [XLEN-1:0] pc_o
);

   localparam int unsigned IAW = $clog2(IMEM_WORDS);
   localparam int unsigned DAW = $clog2(DMEM_WORDS);
   localparam int unsigned RAW = $clog2(NREG);

   if (XLEN != 32) begin : g_bad_xlen
      $error("onecyc_core: the instruction formats fix XLEN at 32");
   end
   if (NREG != 32) begin : g_bad_nreg
      $error("onecyc_core: 5-bit register fields need NREG of 32");
   end
   if (IMEM_WORDS < 2 || (IMEM_WORDS & (IMEM_WORDS - 1)) != 0 || IAW > 28) begin : g_bad_imem
      $error("onecyc_core: IMEM_WORDS must be a power of two between 2 and 2^28");
   end
   if (DMEM_WORDS < 2 || (DMEM_WORDS & (DMEM_WORDS - 1)) != 0 || DAW > 28) begin : g_bad_dmem
      $error("onecyc_core: DMEM_WORDS must be a power of two between 2 and 2^28");
   end

   // ---------------- fetch ----------------
   logic [31:0]     imem_q [IMEM_WORDS];
   logic [XLEN-1:0] pc;
   logic [31:0]     instr;

   initial begin
      for (int i = 0; i < int'(IMEM_WORDS); i++) begin
         imem_q[i] = '0;
      end
   end

   assign instr = imem_q[pc[IAW+1:2]];

   // ---------------- field split ----------------
   logic [5:0]  f_op;
   logic [4:0]  f_rs;
   logic [4:0]  f_rt;
   logic [4:0]  f_rd;
   logic [5:0]  f_funct;
   logic [15:0] f_imm;
   logic [25:0] f_target;

   assign f_op     = instr[31:26];
   assign f_rs     = instr[25:21];
   assign f_rt     = instr[20:16];
   assign f_rd     = instr[15:11];
   assign f_funct  = instr[5:0];
   assign f_imm    = instr[15:0];
   assign f_target = instr[25:0];

   // ---------------- decode ----------------
   ctl_t     ctl;
   alu_req_e areq;
   alu_fn_e  alu_fn;
   logic     fn_ok;

   onecyc_main_ctl main_ctl_i (
      .op_i   (f_op),
      .ctl_o  (ctl),
      .areq_o (areq)
   );

   onecyc_alu_ctl alu_ctl_i (
      .areq_i  (areq),
      .funct_i (f_funct),
      .fn_o    (alu_fn),
      .fn_ok_o (fn_ok)
   );

   // ---------------- register file ----------------
   logic [XLEN-1:0] rs_val;
   logic [XLEN-1:0] rt_val;
   logic            rf_we;
   logic [RAW-1:0]  rf_wa;
   logic [XLEN-1:0] rf_wd;

   assign rf_we = ctl.reg_we && fn_ok && !rst_i;
   assign rf_wa = ctl.dst_rd ? f_rd : f_rt;

   onecyc_regfile #(
      .W        (XLEN),
      .NREG     (NREG),
      .ZERO_REG (1'b1)
   ) rf_i (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .ra_i  (f_rs),
      .rb_i  (f_rt),
      .rda_o (rs_val),
      .rdb_o (rt_val),
      .we_i  (rf_we),
      .wa_i  (rf_wa),
      .wd_i  (rf_wd)
   );

   // ---------------- execute ----------------
   logic [XLEN-1:0] ext_imm;
   logic [XLEN-1:0] alu_b;
   logic [XLEN-1:0] alu_res;
   logic            alu_zero;

   assign ext_imm = ctl.ext_sign ? {{(XLEN - 16){f_imm[15]}}, f_imm}
                                 : {{(XLEN - 16){1'b0}}, f_imm};
   assign alu_b   = ctl.src_imm ? ext_imm : rt_val;

   onecyc_alu #(
      .W            (XLEN),
      .SHARED_ADDER (SHARED_ADDER)
   ) alu_i (
      .fn_i   (alu_fn),
      .a_i    (rs_val),
      .b_i    (alu_b),
      .res_o  (alu_res),
      .zero_o (alu_zero)
   );

   // ---------------- data store ----------------
   logic [XLEN-1:0] dmem_q [DMEM_WORDS];
   logic [DAW-1:0]  dm_idx;
   logic [XLEN-1:0] dm_rd;
   logic            dm_we;

   assign dm_idx = alu_res[DAW+1:2];
   assign dm_rd  = dmem_q[dm_idx];
   assign dm_we  = ctl.mem_we && !rst_i;

   always_ff @(posedge clk_i) begin
      if (dm_we) begin
         dmem_q[dm_idx] <= rt_val;
      end
   end

   // ---------------- write-back ----------------
   assign rf_wd = ctl.wb_mem ? dm_rd : alu_res;

   // ---------------- next PC ----------------
   onecyc_pc_unit #(
      .W (XLEN)
   ) pc_unit_i (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .branch_i (ctl.branch),
      .zero_i   (alu_zero),
      .jump_i   (ctl.jump),
      .imm_i    (f_imm),
      .target_i (f_target),
      .pc_o     (pc)
   );

   assign pc_o = pc;

   // R4: a store, a register write, a branch and a jump never coincide
   a_r4_single_effect: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0({ctl.reg_we, ctl.mem_we, ctl.branch, ctl.jump}));

   // R5: on a subtract the zero flag matches operand equality
   a_r5_zero_flag: assert property (@(posedge clk_i) disable iff (rst_i)
      (alu_fn == ALU_SUB) |-> (alu_zero == (rs_val == alu_b)));

   // R9: no register or data write while reset is held
   a_r9_quiet_in_reset: assert property (@(posedge clk_i)
      rst_i |-> !(rf_we || dm_we));

endmodule

// File: tb/onecyc_core_tb_top.sv
`timescale 1ns/1ps
module onecyc_core_tb_top;

   localparam logic [5:0] T_OP_ORI   = 6'b001101;
   localparam logic [5:0] T_OP_LOAD  = 6'b100011;
   localparam logic [5:0] T_OP_STORE = 6'b101011;
   localparam logic [5:0] T_OP_BEQ   = 6'b000100;
   localparam logic [5:0] T_OP_JMP   = 6'b000010;
   localparam logic [5:0] T_FN_ADD   = 6'b100000;
   localparam logic [5:0] T_FN_SUB   = 6'b100010;

   logic        clk_i = 1'b0;
   logic        rst_i = 1'b1;
   logic [31:0] pc_o;

   int tests = 0;
   int fails = 0;

   logic [31:0] exp_reg [32];
   logic [31:0] exp_mem [64];

   always #2 clk_i = ~clk_i;

   onecyc_core dut_i (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .pc_o  (pc_o)
   );

   function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                         input logic [4:0] rd, input logic [5:0] fn);
      return {6'b000000, rs, rt, rd, 5'b00000, fn};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                         input logic [4:0] rt, input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   function automatic logic [31:0] enc_j(input logic [25:0] tgt);
      return {T_OP_JMP, tgt};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic compare_state(input string req);
      for (int i = 0; i < 32; i++) begin
         chk(req, $sformatf("reg %0d", i), dut_i.rf_i.regs_q[i], exp_reg[i]);
      end
      for (int i = 0; i < 64; i++) begin
         chk(req, $sformatf("dword %0d", i), dut_i.dmem_q[i], exp_mem[i]);
      end
   endtask

   task automatic set_reg(input int idx, input logic [31:0] v);
      dut_i.rf_i.regs_q[idx] <= v;
      exp_reg[idx] = v;
   endtask

   task automatic set_mem(input int idx, input logic [31:0] v);
      dut_i.dmem_q[idx] <= v;
      exp_mem[idx] = v;
   endtask

   task automatic put_instr(input int idx, input logic [31:0] w);
      dut_i.imem_q[idx] = w;
   endtask

   // hold reset, clear the program and load known patterns
   task automatic begin_prog();
      rst_i = 1'b1;
      @(negedge clk_i);
      for (int i = 0; i < 64; i++) begin
         put_instr(i, 32'h0000_0000);
         set_mem(i, 32'hA000_0000 | 32'(i));
      end
      set_reg(0, 32'hDEAD_BEEF);
      for (int i = 1; i < 32; i++) begin
         set_reg(i, 32'h0100_0000 | 32'(i));
      end
   endtask

   task automatic release_rst();
      @(posedge clk_i);
      @(posedge clk_i);
      @(negedge clk_i);
      rst_i = 1'b0;
   endtask

   task automatic run(input int n);
      repeat (n) @(posedge clk_i);
      @(negedge clk_i);
   endtask

   // R1 and R8: register-register arithmetic, register 0 behaviour
   task automatic t_arith();
      begin_prog();
      set_reg(1, 32'd5);
      set_reg(2, 32'd7);
      put_instr(0, enc_r(5'd1, 5'd2, 5'd3, T_FN_ADD));
      put_instr(1, enc_r(5'd1, 5'd2, 5'd4, T_FN_SUB));
      put_instr(2, enc_r(5'd1, 5'd2, 5'd0, T_FN_ADD));
      put_instr(3, enc_r(5'd0, 5'd1, 5'd6, T_FN_ADD));
      put_instr(4, enc_r(5'd0, 5'd2, 5'd7, T_FN_SUB));
      release_rst();
      run(5);
      exp_reg[3] = 32'd12;
      exp_reg[4] = 32'hFFFF_FFFE;
      exp_reg[6] = 32'd5;
      exp_reg[7] = 32'hFFFF_FFF9;
      chk("R1", "add result r3", dut_i.rf_i.regs_q[3], 32'd12);
      chk("R1", "sub wrap r4", dut_i.rf_i.regs_q[4], 32'hFFFF_FFFE);
      chk("R8", "r0 storage after write", dut_i.rf_i.regs_q[0], 32'hDEAD_BEEF);
      chk("R8", "r0 reads zero (r6)", dut_i.rf_i.regs_q[6], 32'd5);
      chk("R7", "pc after five steps", pc_o, 32'd20);
      compare_state("R1");
   endtask

   // R2: OR with zero-extended immediate into bits 20:16
   task automatic t_ori();
      begin_prog();
      set_reg(1, 32'h0000_0010);
      put_instr(0, enc_i(T_OP_ORI, 5'd1, 5'd2, 16'h8001));
      put_instr(1, enc_i(T_OP_ORI, 5'd0, 5'd5, 16'hFFFF));
      release_rst();
      run(2);
      exp_reg[2] = 32'h0000_8011;
      exp_reg[5] = 32'h0000_FFFF;
      chk("R2", "ori zero-extends", dut_i.rf_i.regs_q[2], 32'h0000_8011);
      chk("R2", "bits 15:11 reg untouched", dut_i.rf_i.regs_q[16], 32'h0100_0010);
      chk("R2", "ori from r0", dut_i.rf_i.regs_q[5], 32'h0000_FFFF);
      chk("R2", "pc", pc_o, 32'd8);
      compare_state("R2");
   endtask

   // R3 and R4: load, store, read-back
   task automatic t_mem();
      begin_prog();
      set_reg(1, 32'd16);
      set_mem(3, 32'hCAFE_F00D);
      put_instr(0, enc_i(T_OP_LOAD, 5'd1, 5'd2, 16'hFFFC));
      put_instr(1, enc_i(T_OP_STORE, 5'd1, 5'd2, 16'h0008));
      put_instr(2, enc_i(T_OP_LOAD, 5'd0, 5'd3, 16'h0018));
      put_instr(3, enc_i(T_OP_STORE, 5'd1, 5'd0, 16'h0004));
      release_rst();
      run(1);
      chk("R3", "load negative offset", dut_i.rf_i.regs_q[2], 32'hCAFE_F00D);
      run(1);
      chk("R4", "store word 6", dut_i.dmem_q[6], 32'hCAFE_F00D);
      run(2);
      exp_reg[2] = 32'hCAFE_F00D;
      exp_reg[3] = 32'hCAFE_F00D;
      exp_mem[6] = 32'hCAFE_F00D;
      exp_mem[5] = 32'h0000_0000;
      chk("R3", "load stored word", dut_i.rf_i.regs_q[3], 32'hCAFE_F00D);
      chk("R4", "store of r0", dut_i.dmem_q[5], 32'h0000_0000);
      chk("R3", "reg 31 untouched by imm bits", dut_i.rf_i.regs_q[31], 32'h0100_001F);
      chk("R4", "pc", pc_o, 32'd16);
      compare_state("R4");
   endtask

   // R5: taken, not taken and backward branches
   task automatic t_branch();
      begin_prog();
      set_reg(1, 32'd3);
      set_reg(2, 32'd3);
      set_reg(3, 32'd4);
      put_instr(0, enc_i(T_OP_BEQ, 5'd1, 5'd2, 16'h0002));
      put_instr(1, enc_r(5'd1, 5'd1, 5'd10, T_FN_ADD));
      put_instr(2, enc_r(5'd1, 5'd1, 5'd11, T_FN_ADD));
      put_instr(3, enc_i(T_OP_BEQ, 5'd1, 5'd3, 16'h0005));
      put_instr(4, enc_r(5'd1, 5'd3, 5'd12, T_FN_ADD));
      put_instr(5, enc_i(T_OP_BEQ, 5'd0, 5'd0, 16'hFFFF));
      release_rst();
      run(1);
      chk("R5", "taken forward", pc_o, 32'd12);
      run(1);
      chk("R5", "not taken", pc_o, 32'd16);
      run(3);
      chk("R5", "backward self loop", pc_o, 32'd20);
      exp_reg[12] = 32'd7;
      compare_state("R5");
   endtask

   // R6: jumps, then a zero word runs as no-op
   task automatic t_jump();
      begin_prog();
      set_reg(1, 32'd9);
      put_instr(0, enc_j(26'd4));
      put_instr(1, enc_r(5'd1, 5'd1, 5'd5, T_FN_ADD));
      put_instr(4, enc_r(5'd1, 5'd1, 5'd6, T_FN_ADD));
      put_instr(5, enc_j(26'd8));
      release_rst();
      run(1);
      chk("R6", "jump to word 4", pc_o, 32'd16);
      run(2);
      chk("R6", "jump to word 8", pc_o, 32'd32);
      run(1);
      chk("R7", "zero word steps", pc_o, 32'd36);
      exp_reg[6] = 32'd18;
      chk("R6", "skipped slot r5", dut_i.rf_i.regs_q[5], 32'h0100_0005);
      compare_state("R6");
   endtask

   // R7: unknown opcodes and function fields do nothing
   task automatic t_unsupported();
      begin_prog();
      set_reg(1, 32'd5);
      set_reg(2, 32'd6);
      put_instr(0, enc_i(6'b111111, 5'd1, 5'd2, 16'h0008));
      put_instr(1, enc_r(5'd1, 5'd2, 5'd3, 6'b100101));
      put_instr(2, enc_i(6'b001100, 5'd1, 5'd4, 16'h00FF));
      put_instr(3, enc_r(5'd1, 5'd2, 5'd8, T_FN_ADD));
      release_rst();
      run(3);
      chk("R7", "pc after three no-ops", pc_o, 32'd12);
      chk("R7", "funct no-op r3", dut_i.rf_i.regs_q[3], 32'h0100_0003);
      run(1);
      exp_reg[8] = 32'd11;
      chk("R7", "pc", pc_o, 32'd16);
      compare_state("R7");
   endtask

   // R9: reset clears the PC and blocks writes
   task automatic t_reset();
      begin_prog();
      set_reg(1, 32'd5);
      set_reg(2, 32'd7);
      put_instr(0, enc_r(5'd1, 5'd2, 5'd3, T_FN_ADD));
      release_rst();
      chk("R9", "pc at release", pc_o, 32'd0);
      run(2);
      exp_reg[3] = 32'd12;
      chk("R9", "pc before reset", pc_o, 32'd8);
      rst_i = 1'b1;
      put_instr(0, enc_r(5'd1, 5'd2, 5'd7, T_FN_ADD));
      run(1);
      chk("R9", "pc one edge into reset", pc_o, 32'd0);
      run(2);
      chk("R9", "no write in reset r7", dut_i.rf_i.regs_q[7], 32'h0100_0007);
      compare_state("R9");
      rst_i = 1'b0;
      run(1);
      exp_reg[7] = 32'd12;
      chk("R9", "first instr after reset", dut_i.rf_i.regs_q[7], 32'd12);
      chk("R9", "pc after one step", pc_o, 32'd4);
   endtask

   initial begin
      t_arith();
      t_ori();
      t_mem();
      t_branch();
      t_jump();
      t_unsupported();
      t_reset();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk_i);
      tests++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule